// File: doc/BRIEF.md
# Oversampled Serial Receiver with Per-Character Error Tags

This block receives asynchronous serial characters on a single input line. The line is sampled on an oversampling enable pulse that runs at sixteen times the bit rate. Each character has a start bit, five to eight data bits sent least significant bit first, an optional parity bit and one or two stop bits. The receiver validates the start bit at its middle, then samples every later bit at its centre. It writes the assembled character into a receive queue together with three error tags of its own: parity error, framing error and break.

Status is reported for the character at the head of the queue only. A read strobe on the status port hides the head's tags, and they stay hidden until the head moves on. A framing error does not cost a character. The low level found in the stop position is taken as the start bit of the next character, and data sampling continues from there. A line held low for a whole frame produces a single zero character tagged as a break. After that, the receiver ignores the line until it has been high for two oversample ticks.

Top module: `uart_rx_errtrack`

## Requirements
- R1: A low level on the idle line starts a character only if the line is still low at the eighth oversample tick after the low level was first seen. Otherwise the receiver returns to idle and queues nothing.
- R2: The number of data bits is 5 + cfg_len (cfg_len 0 gives 5 bits, 3 gives 8 bits). Data arrives least significant bit first. Unused high bits of rx_data read 0. A character with high stop bits and correct parity is queued with all three tags clear.
- R3: When cfg_par_en is 1, a parity bit follows the data. With cfg_par_even at 1 the data and parity bits must hold an even number of ones; with cfg_par_even at 0, an odd number. A mismatch sets the parity tag of that character.
- R4: With cfg_stop2 at 1, two stop bits are sampled. A 0 at any sampled stop position sets the framing tag of that character.
- R5: After a framing error, the receiver samples the line one oversample tick later. If the line is still low, it takes that low level as the start bit of the next character, without waiting for a new falling edge, and samples the first data bit 16 ticks after the framing sample.
- R6: If every sample of a frame, stop bits included, is 0, exactly one entry is queued with data 0, the break tag set, and the framing and parity tags clear. No further character is accepted until the line has been high for two consecutive oversample ticks and a valid start bit follows.
- R7: The queue holds 16 entries and keeps arrival order. A character that completes while the queue is full (and no read happens in that cycle) is discarded and sets st_overrun.
- R8: st_ready is 1 exactly when the queue is not empty. rx_data shows the head entry (0 when empty). A pulse on rd_data removes the head entry and has no effect when the queue is empty.
- R9: st_parity, st_frame and st_break show the tags of the head entry only. A pulse on rd_status hides them until the head changes through a read, or until a character enters an empty queue. A pulse on rd_status also clears st_overrun.
- R10: After reset the queue is empty, every status output is 0 and the receiver waits for a start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | Oversample enable, 16 pulses per bit time |
| rx_in | input | 1 | Serial input line, high when idle |
| cfg_len | input | 2 | Data length select, bits = 5 + value |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_even | input | 1 | 1 = even parity, 0 = odd parity |
| cfg_stop2 | input | 1 | 1 = two stop bits |
| rd_data | input | 1 | Pop the head entry |
| rd_status | input | 1 | Status read strobe, hides the head tags and clears overrun |
| rx_data | output | 8 | Data of the head entry |
| st_ready | output | 1 | Queue not empty |
| st_overrun | output | 1 | A character was lost to a full queue |
| st_parity | output | 1 | Head entry has a parity error |
| st_frame | output | 1 | Head entry has a framing error |
| st_break | output | 1 | Head entry is a break |

## Verification
The assertions check on every cycle those properties that hold locally. A break entry is always zero and carries no other tag. The receiver stays silent while it waits after a break. A rejected start returns the receiver to idle. The queue count never exceeds its depth and a full queue does not move its write pointer. A status read hides the tags, and an overrun sets the overrun flag. Only the bench scenarios show the end-to-end behaviour: bit order across all data lengths, parity polarity, resynchronisation that carries a second character on from a bad stop bit, and a single break entry that survives a high glitch and a further long low level. They also show that tags reach the status outputs only when their own character is at the head.

// File: rtl/uart_rx_et_pkg.sv
package uart_rx_et_pkg;

   typedef enum logic [2:0] {
      RX_IDLE,
      RX_START,
      RX_DATA,
      RX_PAR,
      RX_STOP,
      RX_RESYNC,
      RX_BRKWAIT
   } rx_state_e;

   typedef struct packed {
      logic brk;
      logic frm;
      logic par;
   } rx_tags_t;

   localparam int TAG_W = 3;

endpackage

// File: rtl/uart_rx_et_deser.sv
module uart_rx_et_deser
   import uart_rx_et_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int OVS        = 16,
   parameter bit HAS_PARITY = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              rxd_i,
   input  logic [1:0]        dlen_i,
   input  logic              par_en_i,
   input  logic              par_even_i,
   input  logic              two_stop_i,
   output logic              push_o,
   output logic [DATA_W-1:0] data_o,
   output rx_tags_t          tags_o
);

   localparam int CNT_W = $clog2(OVS);
   localparam int MID   = OVS / 2;
   localparam int BIT_W = $clog2(DATA_W + 1);

   rx_state_e         state;
   logic [CNT_W-1:0]  cnt;
   logic [BIT_W-1:0]  bit_idx;
   logic [BIT_W-1:0]  nbits;
   logic [DATA_W-1:0] shreg;
   logic              par_acc;
   logic              perr;
   logic              azero;
   logic              stop_idx;
   logic              hi_seen;
   logic              par_on;
   logic [1:0]        sync_q;
   logic              rxd_s;

   // two-stage synchroniser for the asynchronous line
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= 2'b11;
      else        sync_q <= {sync_q[0], rxd_i};
   end
   assign rxd_s = sync_q[1];

   generate
      if (HAS_PARITY) begin : g_par
         assign par_on = par_en_i;
      end else begin : g_nopar
         assign par_on = 1'b0;
      end
   endgenerate

   assign nbits = BIT_W'(DATA_W - 3) + BIT_W'(dlen_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= RX_IDLE;
         cnt      <= '0;
         bit_idx  <= '0;
         shreg    <= '0;
         par_acc  <= 1'b0;
         perr     <= 1'b0;
         azero    <= 1'b0;
         stop_idx <= 1'b0;
         hi_seen  <= 1'b0;
         push_o   <= 1'b0;
         data_o   <= '0;
         tags_o   <= '0;
      end else begin
         push_o <= 1'b0;
         if (tick_i) begin
            unique case (state)
               RX_IDLE: begin
                  if (!rxd_s) begin
                     state <= RX_START;
                     cnt   <= '0;
                  end
               end
               RX_START: begin
                  if (cnt == CNT_W'(MID - 1)) begin
                     if (rxd_s) begin
                        state <= RX_IDLE;
                     end else begin
                        state    <= RX_DATA;
                        cnt      <= '0;
                        bit_idx  <= '0;
                        shreg    <= '0;
                        par_acc  <= 1'b0;
                        perr     <= 1'b0;
                        azero    <= 1'b1;
                        stop_idx <= 1'b0;
                     end
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               RX_DATA: begin
                  if (cnt == CNT_W'(OVS - 1)) begin
                     cnt     <= '0;
                     shreg   <= shreg | (DATA_W'(rxd_s) << bit_idx);
                     par_acc <= par_acc ^ rxd_s;
                     azero   <= azero & ~rxd_s;
                     if (bit_idx == nbits - BIT_W'(1)) begin
                        state <= par_on ? RX_PAR : RX_STOP;
                     end else begin
                        bit_idx <= bit_idx + 1'b1;
                     end
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               RX_PAR: begin
                  if (cnt == CNT_W'(OVS - 1)) begin
                     cnt   <= '0;
                     perr  <= par_acc ^ rxd_s ^ ~par_even_i;
                     azero <= azero & ~rxd_s;
                     state <= RX_STOP;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               RX_STOP: begin
                  if (cnt == CNT_W'(OVS - 1)) begin
                     cnt <= '0;
                     if (!rxd_s) begin
                        push_o <= 1'b1;
                        if (azero) begin
                           data_o  <= '0;
                           tags_o  <= '{brk: 1'b1, frm: 1'b0, par: 1'b0};
                           hi_seen <= 1'b0;
                           state   <= RX_BRKWAIT;
                        end else begin
                           data_o <= shreg;
                           tags_o <= '{brk: 1'b0, frm: 1'b1, par: perr};
                           state  <= RX_RESYNC;
                        end
                     end else if (two_stop_i && !stop_idx) begin
                        stop_idx <= 1'b1;
                     end else begin
                        push_o <= 1'b1;
                        data_o <= shreg;
                        tags_o <= '{brk: 1'b0, frm: 1'b0, par: perr};
                        state  <= RX_IDLE;
                     end
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               RX_RESYNC: begin
                  // second look at the low stop level, now taken as a start bit
                  if (!rxd_s) begin
                     state    <= RX_DATA;
                     cnt      <= CNT_W'(1);
                     bit_idx  <= '0;
                     shreg    <= '0;
                     par_acc  <= 1'b0;
                     perr     <= 1'b0;
                     azero    <= 1'b1;
                     stop_idx <= 1'b0;
                  end else begin
                     state <= RX_IDLE;
                  end
               end
               RX_BRKWAIT: begin
                  if (rxd_s) begin
                     if (hi_seen) state <= RX_IDLE;
                     else         hi_seen <= 1'b1;
                  end else begin
                     hi_seen <= 1'b0;
                  end
               end
               default: state <= RX_IDLE;
            endcase
         end
      end
   end

   // R6: a break entry is zero and carries only the break tag
   p_brk_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (push_o && tags_o.brk) |-> (data_o == '0 && !tags_o.frm && !tags_o.par));

   // R6: nothing is queued while waiting for a marking line
   p_brkwait_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == RX_BRKWAIT) |=> !push_o);

   // R1: a high line at mid-start abandons the character
   p_false_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (state == RX_START && tick_i && cnt == CNT_W'(MID - 1) && rxd_s)
      |=> (state == RX_IDLE && !push_o));

   // R5: a still-low line after a framing error goes straight to data
   p_resync_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == RX_RESYNC && tick_i && !rxd_s) |=> (state == RX_DATA));

endmodule

// File: rtl/uart_rx_et_fifo.sv
module uart_rx_et_fifo #(
   parameter int WIDTH = 11,
   parameter int DEPTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_i,
   input  logic [WIDTH-1:0] din_i,
   input  logic             pop_i,
   output logic [WIDTH-1:0] dout_o,
   output logic             empty_o,
   output logic             ovf_o
);

   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = $clog2(DEPTH + 1);

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CNT_W-1:0] count;
   logic             full, do_push, do_pop;

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("receive queue needs at least two entries");
      end
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_wrap
         assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   assign empty_o = (count == '0);
   assign full    = (count == CNT_W'(DEPTH));
   assign do_pop  = pop_i && !empty_o;
   assign do_push = push_i && (!full || do_pop);
   assign ovf_o   = push_i && full && !do_pop;
   assign dout_o  = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= din_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_nxt;
         if (do_pop)  rd_ptr <= rd_nxt;
         unique case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   // R7: occupancy bounded by the depth
   p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(DEPTH));

   // R7: a full queue with no read keeps its write side still
   p_full_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push_i && !pop_i) |=> (full && $stable(wr_ptr)));

   // R8: reading the last entry empties the queue
   p_pop_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (count == CNT_W'(1) && pop_i && !push_i) |=> empty_o);

endmodule

// File: rtl/uart_rx_et_status.sv
module uart_rx_et_status
   import uart_rx_et_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     empty_i,
   input  rx_tags_t head_tags_i,
   input  logic     push_i,
   input  logic     pop_i,
   input  logic     ovf_i,
   input  logic     rd_stat_i,
   output logic     st_ready_o,
   output logic     st_overrun_o,
   output logic     st_parity_o,
   output logic     st_frame_o,
   output logic     st_break_o
);

   logic hide, oe_q, show;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hide <= 1'b0;
         oe_q <= 1'b0;
      end else begin
         if (pop_i || (empty_i && push_i)) hide <= 1'b0;
         else if (rd_stat_i)               hide <= 1'b1;
         if (ovf_i)          oe_q <= 1'b1;
         else if (rd_stat_i) oe_q <= 1'b0;
      end
   end

   assign show         = !empty_i && !hide;
   assign st_ready_o   = !empty_i;
   assign st_overrun_o = oe_q;
   assign st_parity_o  = show && head_tags_i.par;
   assign st_frame_o   = show && head_tags_i.frm;
   assign st_break_o   = show && head_tags_i.brk;

   // R9: a status read with a steady head hides the tags
   p_read_hides_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stat_i && !pop_i && !push_i) |=> (!st_parity_o && !st_frame_o && !st_break_o));

   // R7: a lost character raises the overrun flag
   p_oe_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_i |=> st_overrun_o);

endmodule

// File: rtl/uart_rx_errtrack.sv
module uart_rx_errtrack
   import uart_rx_et_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int OVS        = 16,
   parameter int FIFO_DEPTH = 16,
   parameter bit HAS_PARITY = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              os_tick,
   input  logic              rx_in,
   input  logic [1:0]        cfg_len,
   input  logic              cfg_par_en,
   input  logic              cfg_par_even,
   input  logic              cfg_stop2,
   input  logic              rd_data,
   input  logic              rd_status,
   output logic [DATA_W-1:0] rx_data,
   output logic              st_ready,
   output logic              st_overrun,
   output logic              st_parity,
   output logic              st_frame,
   output logic              st_break
);

   localparam int FW = DATA_W + TAG_W;

   generate
      if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs
         $error("oversample ratio must be even and at least 4");
      end
      if (DATA_W < 5) begin : g_bad_width
         $error("data width must allow at least five data bits");
      end
   endgenerate

   logic              push, empty, ovf, pop;
   logic [DATA_W-1:0] pdata;
   rx_tags_t          ptags, htags;
   logic [FW-1:0]     fdout;

   assign pop = rd_data && !empty;

   uart_rx_et_deser #(
      .DATA_W     (DATA_W),
      .OVS        (OVS),
      .HAS_PARITY (HAS_PARITY)
   ) u_deser (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_i     (os_tick),
      .rxd_i      (rx_in),
      .dlen_i     (cfg_len),
      .par_en_i   (cfg_par_en),
      .par_even_i (cfg_par_even),
      .two_stop_i (cfg_stop2),
      .push_o     (push),
      .data_o     (pdata),
      .tags_o     (ptags)
   );

   uart_rx_et_fifo #(
      .WIDTH (FW),
      .DEPTH (FIFO_DEPTH)
   ) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .push_i  (push),
      .din_i   ({ptags, pdata}),
      .pop_i   (pop),
      .dout_o  (fdout),
      .empty_o (empty),
      .ovf_o   (ovf)
   );

   assign htags   = rx_tags_t'(fdout[FW-1:DATA_W]);
   assign rx_data = empty ? '0 : fdout[DATA_W-1:0];

   uart_rx_et_status u_status (
      .clk          (clk),
      .rst_n        (rst_n),
      .empty_i      (empty),
      .head_tags_i  (htags),
      .push_i       (push),
      .pop_i        (pop),
      .ovf_i        (ovf),
      .rd_stat_i    (rd_status),
      .st_ready_o   (st_ready),
      .st_overrun_o (st_overrun),
      .st_parity_o  (st_parity),
      .st_frame_o   (st_frame),
      .st_break_o   (st_break)
   );

endmodule

// File: tb/sim_uart_rx_errtrack.sv
`timescale 1ns/1ps
module sim_uart_rx_errtrack;

   localparam int DW      = 8;
   localparam int OVS     = 16;
   localparam int DEPTH   = 16;
   localparam int BIT_CLK = OVS * 2;

   logic       clk = 1'b0;
   logic       rst_n, tick, rxd;
   logic [1:0] cfg_len;
   logic       cfg_par_en, cfg_par_even, cfg_stop2, rd_data, rd_status;
   logic [DW-1:0] rx_data;
   logic       st_ready, st_overrun, st_parity, st_frame, st_break;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;
   logic [DW+2:0] expq [$];

   always #2 clk = ~clk;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tick <= 1'b0;
      else        tick <= ~tick;
   end

   uart_rx_errtrack u0 (
      .clk(clk), .rst_n(rst_n), .os_tick(tick), .rx_in(rxd),
      .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even),
      .cfg_stop2(cfg_stop2), .rd_data(rd_data), .rd_status(rd_status),
      .rx_data(rx_data), .st_ready(st_ready), .st_overrun(st_overrun),
      .st_parity(st_parity), .st_frame(st_frame), .st_break(st_break)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] lmask(input int len);
      return DW'((1 << len) - 1);
   endfunction

   function automatic logic good_par(input logic [DW-1:0] d, input int len, input logic even);
      logic x;
      x = ^(d & lmask(len));
      return even ? x : ~x;
   endfunction

   task automatic hold(input logic b, input int nb);
      rxd = b;
      repeat (nb * BIT_CLK) @(negedge clk);
   endtask

   task automatic set_cfg(input int len, input logic pen, input logic peven, input logic stop2);
      cfg_len      = 2'(len - 5);
      cfg_par_en   = pen;
      cfg_par_even = peven;
      cfg_stop2    = stop2;
   endtask

   task automatic send_frame(input logic [DW-1:0] d, input int len, input logic pen,
                             input logic peven, input logic stop2, input logic flip);
      hold(1'b0, 1);
      for (int i = 0; i < len; i++) hold(d[i], 1);
      if (pen) hold(good_par(d, len, peven) ^ flip, 1);
      hold(1'b1, stop2 ? 2 : 1);
      hold(1'b1, 1);
      expq.push_back({1'b0, 1'b0, pen & flip, d & lmask(len)});
   endtask

   // bad stop level doubles as the start of the second character (R4, R5)
   task automatic send_fe_pair(input logic [DW-1:0] a, input logic [DW-1:0] b,
                               input int len, input logic stop2);
      hold(1'b0, 1);
      for (int i = 0; i < len; i++) hold(a[i], 1);
      if (stop2) hold(1'b1, 1);
      hold(1'b0, 1);
      for (int i = 0; i < len; i++) hold(b[i], 1);
      hold(1'b1, stop2 ? 2 : 1);
      hold(1'b1, 1);
      expq.push_back({1'b0, 1'b1, 1'b0, a & lmask(len)});
      expq.push_back({1'b0, 1'b0, 1'b0, b & lmask(len)});
   endtask

   task automatic pulse_rd;
      rd_data = 1'b1;
      @(negedge clk);
      rd_data = 1'b0;
   endtask

   task automatic pulse_stat;
      rd_status = 1'b1;
      @(negedge clk);
      rd_status = 1'b0;
   endtask

   task automatic drain(input string tag);
      logic [DW+2:0] e;
      while (expq.size() > 0) begin
         e = expq.pop_front();
         chk({tag, " R8 ready"}, 32'(st_ready), 32'd1);
         chk({tag, " R2 data"}, 32'(rx_data), 32'(e[DW-1:0]));
         chk({tag, " R3/R9 parity tag"}, 32'(st_parity), 32'(e[DW]));
         chk({tag, " R4/R9 frame tag"}, 32'(st_frame), 32'(e[DW+1]));
         chk({tag, " R6/R9 break tag"}, 32'(st_break), 32'(e[DW+2]));
         pulse_rd();
      end
      chk({tag, " R8 empty after reads"}, 32'(st_ready), 32'd0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      int seed_v;
      seed_v = $urandom(32'd7919);
      rst_n = 1'b0; rxd = 1'b1; rd_data = 1'b0; rd_status = 1'b0;
      set_cfg(8, 1'b0, 1'b0, 1'b0);
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      // R10 reset state
      chk("R10 ready", 32'(st_ready), 32'd0);
      chk("R10 overrun", 32'(st_overrun), 32'd0);
      chk("R10 tags", 32'({st_parity, st_frame, st_break}), 32'd0);
      chk("R10 data", 32'(rx_data), 32'd0);

      // R1 short low pulse is not a start bit
      rxd = 1'b0;
      repeat (6) @(negedge clk);
      hold(1'b1, 3);
      chk("R1 glitch queues nothing", 32'(st_ready), 32'd0);

      // R8 read of an empty queue
      pulse_rd();
      chk("R8 read on empty", 32'(st_ready), 32'd0);

      // R2 every data length
      for (int len = 5; len <= 8; len++) begin
         set_cfg(len, 1'b0, 1'b0, 1'b0);
         send_frame(8'hA5 ^ 8'(len), len, 1'b0, 1'b0, 1'b0, 1'b0);
         send_frame(8'hFF, len, 1'b0, 1'b0, 1'b0, 1'b0);
      end
      drain("R2");

      // R3 parity polarity, good and bad; head-only tags (R9)
      for (int k = 0; k < 4; k++) begin
         set_cfg(7, 1'b1, k[0], 1'b0);
         send_frame(8'h3C + 8'(k), 7, 1'b1, k[0], 1'b0, k[1]);
      end
      drain("R3");

      // R9 status read hides the head tags until the next pop
      set_cfg(8, 1'b1, 1'b1, 1'b0);
      send_frame(8'h96, 8, 1'b1, 1'b1, 1'b0, 1'b1);
      void'(expq.pop_back());
      chk("R9 parity visible", 32'(st_parity), 32'd1);
      pulse_stat();
      chk("R9 parity hidden", 32'(st_parity), 32'd0);
      chk("R9 entry kept", 32'(st_ready), 32'd1);
      chk("R9 data kept", 32'(rx_data), 32'h96);
      pulse_rd();
      chk("R9 queue empty", 32'(st_ready), 32'd0);

      // R4/R5 framing error with resync, one and two stop bits
      set_cfg(8, 1'b0, 1'b0, 1'b0);
      send_fe_pair(8'h5A, 8'hC3, 8, 1'b0);
      set_cfg(6, 1'b0, 1'b0, 1'b1);
      send_fe_pair(8'h2B, 8'h11, 6, 1'b1);
      send_frame(8'h0F, 6, 1'b0, 1'b0, 1'b1, 1'b0);
      drain("R4/R5");

      // R6 break: one entry, then wait for a marking line
      set_cfg(8, 1'b1, 1'b0, 1'b1);
      hold(1'b0, 13);
      expq.push_back({1'b1, 1'b0, 1'b0, 8'h00});
      rxd = 1'b1;
      repeat (2) @(negedge clk);
      hold(1'b0, 12);
      hold(1'b1, 2);
      send_frame(8'h81, 8, 1'b1, 1'b0, 1'b1, 1'b0);
      drain("R6");

      // R7 overrun on a full queue
      set_cfg(8, 1'b0, 1'b0, 1'b0);
      for (int i = 0; i < DEPTH; i++) send_frame(8'(i * 13 + 1), 8, 1'b0, 1'b0, 1'b0, 1'b0);
      chk("R7 no overrun at depth", 32'(st_overrun), 32'd0);
      send_frame(8'hEE, 8, 1'b0, 1'b0, 1'b0, 1'b0);
      void'(expq.pop_back());
      chk("R7 overrun set", 32'(st_overrun), 32'd1);
      pulse_stat();
      chk("R9 overrun cleared by status read", 32'(st_overrun), 32'd0);
      drain("R7");

      // random frames
      for (int f = 0; f < 60; f++) begin
         int len;
         logic pen, pev, st2, flp;
         logic [DW-1:0] d;
         len = 5 + int'($urandom_range(3));
         pen = 1'($urandom_range(1));
         pev = 1'($urandom_range(1));
         st2 = 1'($urandom_range(1));
         flp = ($urandom_range(3) == 0);
         d   = 8'($urandom);
         set_cfg(len, pen, pev, st2);
         send_frame(d, len, pen, pev, st2, flp);
         if (expq.size() >= 1 + int'($urandom_range(3))) drain("R2/R3 random");
      end
      drain("R2/R3 random");

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule